// File: doc/BRIEF.md
# Windowed Boundary Signature Generator

This block watches a 13-bit data bus and its valid strobe at the edge of a larger block and compresses them into a 16-bit signature. Lab software sets a window length in cycles and a starting seed, pulses start, waits for done, then reads the signature and compares it with a value predicted offline. The block is a passive observer. It never stalls the bus it watches, so the monitored pins have no ready signal and apply no back-pressure. The data lines are sampled on every cycle of the window whatever the valid strobe says. A data value left on the bus by earlier traffic therefore still changes the result.

The compression register is a multiple-input signature register with feedback taps x^16 + x^12 + x^3 + x + 1. A down-counter sets the length of the window, and a small controller handles loading, running and holding the result.

Top module: `siggen_window`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `sig_out` = 0 and `done` = 0.
- R2: A clock edge with `start` high loads `cfg_seed` into `sig_out` and latches `cfg_len`. `sig_out` equals the seed in the cycle after the start.
- R3: Each compression step computes next = ({s[14:0],0} XOR (s[15] ? 16'h100B : 0)) XOR {2'b00, mon_valid, mon_data}. The valid bit sits at position 13 and data bits 12..0 sit at positions 12..0.
- R4: For `cfg_len` = N > 0, exactly N steps are applied. They use the input values present at the N clock edges that follow the start edge.
- R5: A step is applied on every cycle of the window even when `mon_valid` is 0, so data held on the bus during idle cycles changes the signature.
- R6: `done` is 0 during the window and rises in the cycle after the edge that applies the last step.
- R7: While `done` is 1 and no start arrives, `sig_out` and `done` do not change, whatever the monitored inputs do.
- R8: A start during a running window abandons it. Compression restarts from the new seed for the new length.
- R9: A start with `cfg_len` = 0 makes `done` 1 in the next cycle, with `sig_out` equal to the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that loads the seed and opens a window |
| cfg_len | input | 16 | Window length in cycles, latched on start |
| cfg_seed | input | 16 | Initial signature value, loaded on start |
| mon_data | input | 13 | Monitored data bus |
| mon_valid | input | 1 | Monitored valid strobe, compressed as bit 13 |
| sig_out | output | 16 | Running signature; holds the final value once done |
| done | output | 1 | High from the end of the window until the next start or reset |

## Verification
The hardest case to reach from the ports is a window in which `mon_valid` stays low while a data value from an earlier window is still on the bus. The bench drives such windows with two different held values. It checks that each result matches its own model and that the two signatures differ. A second hard case is a restart that lands partway through a window. The bench reaches it by pulsing start again a few samples into a long window, then checks the full new window from the new seed.

// File: rtl/sigwin_pkg.sv
package sigwin_pkg;
  localparam int SIG_W = 16;
  localparam int DATA_W = 13;
  localparam int TAP_W = DATA_W + 1;
  localparam int LEN_W = 16;
  localparam logic [SIG_W-1:0] FB_POLY = 16'h100B;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HELD = 2'd2
  } win_state_e;
endpackage

// File: rtl/sigwin_misr.sv
module sigwin_misr #(
  parameter int W = 16,
  parameter int IN_W = 14,
  parameter logic [W-1:0] POLY = 16'h100B
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            shift,
  input  logic [W-1:0]    seed,
  input  logic [IN_W-1:0] tap_in,
  output logic [W-1:0]    state
);
  logic [W-1:0] tap_ext;
  logic [W-1:0] nxt;
  logic         fb;

  generate
    if (W > IN_W) begin : g_pad
      assign tap_ext = {{(W-IN_W){1'b0}}, tap_in};
    end else begin : g_nopad
      assign tap_ext = tap_in[W-1:0];
    end
  endgenerate

  assign fb = state[W-1];

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign nxt[i] = (fb & POLY[i]) ^ tap_ext[i];
      end else begin : g_up
        assign nxt[i] = state[i-1] ^ (fb & POLY[i]) ^ tap_ext[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        state <= '0;
    else if (load)  state <= seed;
    else if (shift) state <= nxt;
  end
endmodule

// File: rtl/sigwin_counter.sv
module sigwin_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          dec,
  input  logic [CW-1:0] len,
  output logic          len_zero,
  output logic          last
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] cnt;

  assign len_zero = (len == '0);
  assign last     = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= len;
    else if (dec && cnt != '0)  cnt <= cnt - ONE;
  end
endmodule

// File: rtl/sigwin_ctrl.sv
module sigwin_ctrl
  import sigwin_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic len_zero,
  input  logic last,
  output logic load,
  output logic shift,
  output logic done
);
  win_state_e st;

  assign load  = start;
  assign shift = (st == ST_RUN) && !start;
  assign done  = (st == ST_HELD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
    end else if (start) begin
      st <= len_zero ? ST_HELD : ST_RUN;
    end else if (st == ST_RUN && last) begin
      st <= ST_HELD;
    end
  end
endmodule

// File: rtl/siggen_window.sv
module siggen_window
  import sigwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [SIG_W-1:0]  cfg_seed,
  input  logic [DATA_W-1:0] mon_data,
  input  logic              mon_valid,
  output logic [SIG_W-1:0]  sig_out,
  output logic              done
);
  logic load, shift, len_zero, last;
  logic [TAP_W-1:0] tap;

  assign tap = {mon_valid, mon_data};

  sigwin_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .len_zero(len_zero), .last(last),
    .load(load), .shift(shift), .done(done)
  );

  sigwin_counter #(.CW(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .dec(shift), .len(cfg_len),
    .len_zero(len_zero), .last(last)
  );

  sigwin_misr #(.W(SIG_W), .IN_W(TAP_W), .POLY(FB_POLY)) u_misr (
    .clk(clk), .rst(rst), .load(load), .shift(shift), .seed(cfg_seed),
    .tap_in(tap), .state(sig_out)
  );
endmodule

// File: rtl/siggen_window_checker.sv
module siggen_window_checker (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [15:0] cfg_len,
  input logic [15:0] cfg_seed,
  input logic [15:0] sig_out,
  input logic        done
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  // R1: state after a reset edge
  always @(posedge clk) begin
    if (was_rst === 1'b1)
      a_r1_reset_clears: assert (sig_out == 16'h0 && done == 1'b0);
  end

  a_r2_seed_load: assert property (@(posedge clk) disable iff (rst)
    start |=> sig_out == $past(cfg_seed));

  a_r6_open_not_done: assert property (@(posedge clk) disable iff (rst)
    (start && cfg_len != 16'h0) |=> !done);

  a_r7_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(sig_out)));

  a_r9_zero_len_done: assert property (@(posedge clk) disable iff (rst)
    (start && cfg_len == 16'h0) |=> done);
endmodule

bind siggen_window siggen_window_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len),
  .cfg_seed(cfg_seed), .sig_out(sig_out), .done(done)
);

// File: tb/siggen_window_test.sv
`timescale 1ns/1ps
module siggen_window_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] cfg_len = '0;
  logic [15:0] cfg_seed = '0;
  logic [12:0] mon_data = '0;
  logic        mon_valid = 1'b0;
  logic [15:0] sig_out;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [12:0] held_val = 13'h0;

  always #5 clk = ~clk;

  siggen_window uut (
    .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len), .cfg_seed(cfg_seed),
    .mon_data(mon_data), .mon_valid(mon_valid), .sig_out(sig_out), .done(done)
  );

  typedef struct packed {
    logic [15:0] seed;
    logic [15:0] len;
    logic [1:0]  pat;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{seed: 16'hACE1, len: 16'd1,  pat: 2'd0},
    '{seed: 16'h0000, len: 16'd17, pat: 2'd0},
    '{seed: 16'hFFFF, len: 16'd33, pat: 2'd1},
    '{seed: 16'h1234, len: 16'd8,  pat: 2'd3},
    '{seed: 16'h8001, len: 16'd40, pat: 2'd3},
    '{seed: 16'h5A5A, len: 16'd2,  pat: 2'd1}
  };

  // R3: reference step written from the requirement
  function automatic logic [15:0] step(input logic [15:0] s, input logic [13:0] t);
    logic [15:0] r;
    r = {s[14:0], 1'b0};
    if (s[15]) r = r ^ 16'h100B;
    return r ^ {2'b00, t};
  endfunction

  function automatic logic [13:0] gen(input logic [1:0] pat, input int k);
    case (pat)
      2'd0:    return {1'b1, 13'(k * 37 + 5)};
      2'd1:    return {1'(k & 1), 13'(k * 101)};
      2'd2:    return {1'b0, held_val};
      default: return {1'(((k >> 1) ^ k) & 1), 13'(k * k + 13'h1555)};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_window(input logic [15:0] seed, input logic [15:0] len,
                            input logic [1:0] pat, output logic [15:0] res);
    logic [15:0] e;
    e = seed;
    @(negedge clk);
    start = 1'b1; cfg_seed = seed; cfg_len = len;
    {mon_valid, mon_data} = gen(pat, 0);
    @(negedge clk);
    start = 1'b0;
    chk(sig_out == seed, "R2 seed loaded", sig_out, seed);
    chk(done == (len == 0), "R6/R9 done after start", 16'(done), 16'(len == 0));
    for (int k = 1; k <= int'(len); k++) begin
      {mon_valid, mon_data} = gen(pat, k);
      e = step(e, gen(pat, k));
      @(negedge clk);
      if (k < int'(len)) chk(done == 1'b0, "R6 done low inside window", 16'(done), 16'h0);
    end
    chk(sig_out == e, "R3/R4 final signature", sig_out, e);
    chk(done == 1'b1, "R6 done at end", 16'(done), 16'h1);
    res = e;
  endtask

  initial begin
    logic [15:0] r, ra, rb, frozen;
    repeat (3) @(negedge clk);
    chk(sig_out == 16'h0, "R1 reset signature", sig_out, 16'h0);
    chk(done == 1'b0, "R1 reset done", 16'(done), 16'h0);
    rst = 1'b0;

    foreach (VECS[i]) run_window(VECS[i].seed, VECS[i].len, VECS[i].pat, r);

    // R7: freeze while inputs keep moving
    frozen = sig_out;
    for (int k = 0; k < 6; k++) begin
      {mon_valid, mon_data} = gen(2'd0, k + 90);
      @(negedge clk);
      chk(sig_out == frozen && done, "R7 held after done", sig_out, frozen);
    end

    // R9: zero-length window
    run_window(16'hBEEF, 16'd0, 2'd0, r);
    @(negedge clk);
    chk(sig_out == 16'hBEEF, "R9 seed kept for zero length", sig_out, 16'hBEEF);

    // R5: valid low, stale data decides the signature
    held_val = 13'h0ABC;
    run_window(16'h0F0F, 16'd12, 2'd2, ra);
    held_val = 13'h1543;
    run_window(16'h0F0F, 16'd12, 2'd2, rb);
    chk(ra != rb, "R5 stale data changes signature", ra, rb);

    // R8: restart partway through a window
    @(negedge clk);
    start = 1'b1; cfg_seed = 16'h7777; cfg_len = 16'd25;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      {mon_valid, mon_data} = gen(2'd1, k);
      @(negedge clk);
    end
    chk(done == 1'b0, "R8 window still open", 16'(done), 16'h0);
    run_window(16'h3C3C, 16'd9, 2'd3, r);

    // R1: reset in the middle of a window
    @(negedge clk);
    start = 1'b1; cfg_seed = 16'h9999; cfg_len = 16'd30;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(sig_out == 16'h0, "R1 mid-window reset signature", sig_out, 16'h0);
    chk(done == 1'b0, "R1 mid-window reset done", 16'(done), 16'h0);
    repeat (5) @(negedge clk);
    chk(done == 1'b0 && sig_out == 16'h0, "R1 stays idle after reset", sig_out, 16'h0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule